// File: doc/BRIEF.md
# Tick Timer with Match Modes

A processor tick timer built from a 32-bit up-counter and a 32-bit mode register. The counter advances by one on every cycle in which the tick enable input is high and the timer is running. In a typical system, the tick enable pulses at the timer rate, for example one pulse every 50 ns for a 20 MHz tick. Software writes either register through a single-cycle write port. Both registers are always visible on the read outputs.

The low 28 bits of the mode register hold a match period. On a running tick, the low 28 bits of the counter are compared against this period. When they are equal, the two-bit mode field selects the action: no action, restart from zero, stop (one-shot), or keep counting (continuous). If interrupts are enabled, a match also latches a pending flag. The level interrupt output is the pending flag gated by the enable. Software clears the pending flag by writing zero to it.

Top module: `tick_timer`

## Requirements
- R1: After reset, the counter reads 0, the mode register reads 0 and `irq_o` is 0.
- R2: While running, the counter increments by one (wrapping modulo 2^32) on each clock edge with `tick_en_i` high. It holds its value on edges where `tick_en_i` is low, and on every edge while stopped.
- R3: A write with `wr_sel_i`=0 loads `wr_data_i` into the counter, visible on the next cycle. Such a write takes priority over a tick in the same cycle.
- R4: A match is an edge where the timer is running, `tick_en_i` is high and the counter's bits 27:0 equal the period field (mode register bits 27:0). On a match with the enable bit (bit 29) set, the pending bit (bit 28) becomes 1. With the enable bit clear, a match leaves the pending bit unchanged.
- R5: With mode field (bits 31:30) = 01 (restart), a match loads the counter with 0 and counting continues.
- R6: With mode field = 11 (continuous), a match does not disturb the counter, which increments as usual.
- R7: The pending bit is cleared only by a mode-register write (`wr_sel_i`=1) with bit 28 = 0. Writing 1 to bit 28 never sets the bit. A match in the same cycle as a clearing write leaves the bit set.
- R8: `irq_o` equals the pending bit AND the enable bit of the mode register.
- R9: With mode field = 10 (one-shot), a match stops the counter, which holds the matched value until a mode write with a non-zero mode restarts it.
- R10: Counter bits 31:28 take no part in the match comparison.
- R11: A mode write with mode field 00 stops counting. A mode write with any other mode starts counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_en_i | input | 1 | Tick enable, one count per high cycle |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 counter, 1 mode register |
| wr_data_i | input | 32 | Write data |
| count_o | output | 32 | Current counter value |
| mode_o | output | 32 | Mode register: 31:30 mode, 29 enable, 28 pending, 27:0 period |
| irq_o | output | 1 | Level timer interrupt |

## Verification
The assertions assume that every input is at a known value after reset. They also assume that a write, being a single-cycle strobe, is sampled only on the edge where `wr_en_i` is high. The hold and increment properties therefore treat any write edge as a legitimate disturbance of the counter. The bench drives all inputs one time unit after the rising edge and always to defined values. Its writes last exactly one cycle. Its tick patterns include gaps, so that the properties that depend on `tick_en_i` are exercised in both states.

// File: rtl/tt_pkg.sv
package tt_pkg;
  typedef enum logic [1:0] {
    MODE_OFF     = 2'b00,
    MODE_RESTART = 2'b01,
    MODE_ONESHOT = 2'b10,
    MODE_CONT    = 2'b11
  } tt_mode_e;
endpackage

// File: rtl/tt_match.sv
module tt_match #(
  parameter int unsigned PER_W = 28
) (
  input  logic [PER_W-1:0] cnt_per_i,
  input  logic [PER_W-1:0] period_i,
  input  logic             run_i,
  input  logic             tick_i,
  output logic             hit_o
);
  // only period bits compared; upper count bits wrap freely
  always_comb hit_o = run_i && tick_i && (cnt_per_i == period_i);
endmodule

// File: rtl/tt_counter.sv
module tt_counter
  import tt_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             hit_i,
  input  tt_mode_e         mode_i,
  input  logic             cnt_we_i,
  input  logic [CNT_W-1:0] cnt_wdata_i,
  input  logic             mode_we_i,
  input  tt_mode_e         mode_wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             run_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             run_q, run_d;

  always_comb begin
    cnt_d = cnt_q;
    if (cnt_we_i) begin
      cnt_d = cnt_wdata_i;
    end else if (run_q && tick_i) begin
      if (hit_i && mode_i == MODE_RESTART)      cnt_d = '0;
      else if (hit_i && mode_i == MODE_ONESHOT) cnt_d = cnt_q;
      else                                      cnt_d = cnt_q + 1'b1;
    end
  end

  always_comb begin
    run_d = run_q;
    if (mode_we_i)                           run_d = (mode_wdata_i != MODE_OFF);
    else if (hit_i && mode_i == MODE_ONESHOT) run_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      run_q <= run_d;
    end
  end

  assign cnt_o = cnt_q;
  assign run_o = run_q;

  // R2
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cnt_we_i && (!tick_i || !run_q)) |=> $stable(cnt_q));
  // R2
  cnt_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cnt_we_i && tick_i && run_q && !hit_i) |=> (cnt_q == $past(cnt_q) + 1'b1));
  // R5
  restart_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cnt_we_i && hit_i && mode_i == MODE_RESTART) |=> (cnt_q == '0));
  // R9
  oneshot_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_we_i && hit_i && mode_i == MODE_ONESHOT) |=> !run_q);
  // R11
  off_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_we_i && mode_wdata_i == MODE_OFF) |=> !run_q);
endmodule

// File: rtl/tt_mode_reg.sv
module tt_mode_reg
  import tt_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic             hit_i,
  output tt_mode_e         mode_o,
  output logic             ie_o,
  output logic             pend_o,
  output logic [CNT_W-5:0] period_o
);
  localparam int unsigned PER_W   = CNT_W - 4;
  localparam int unsigned IE_BIT  = CNT_W - 3;
  localparam int unsigned IP_BIT  = CNT_W - 4;

  tt_mode_e         mode_q;
  logic             ie_q, pend_q, pend_set;
  logic [PER_W-1:0] per_q;

  always_comb pend_set = hit_i && ie_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_OFF;
      ie_q   <= 1'b0;
      pend_q <= 1'b0;
      per_q  <= '0;
    end else if (we_i) begin
      mode_q <= tt_mode_e'(wdata_i[CNT_W-1:CNT_W-2]);
      ie_q   <= wdata_i[IE_BIT];
      per_q  <= wdata_i[PER_W-1:0];
      // writing 1 keeps, writing 0 clears; a match wins
      pend_q <= pend_set || (pend_q && wdata_i[IP_BIT]);
    end else begin
      pend_q <= pend_q || pend_set;
    end
  end

  assign mode_o   = mode_q;
  assign ie_o     = ie_q;
  assign pend_o   = pend_q;
  assign period_o = per_q;

  // R4
  pend_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pend_q) |-> $past(hit_i));
  // R7
  pend_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !we_i) |=> pend_q);
  // R7
  pend_set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_i && ie_q) |=> pend_q);
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tt_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_en_i,
  input  logic             wr_en_i,
  input  logic             wr_sel_i,
  input  logic [CNT_W-1:0] wr_data_i,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] mode_o,
  output logic             irq_o
);
  localparam int unsigned PER_W = CNT_W - 4;

  logic             cnt_we, mode_we, hit, run, ie, pend;
  logic [CNT_W-1:0] cnt;
  logic [PER_W-1:0] period;
  tt_mode_e         mode;

  assign cnt_we  = wr_en_i && !wr_sel_i;
  assign mode_we = wr_en_i && wr_sel_i;

  tt_match #(.PER_W(PER_W)) u_match (
    .cnt_per_i (cnt[PER_W-1:0]),
    .period_i  (period),
    .run_i     (run),
    .tick_i    (tick_en_i),
    .hit_o     (hit)
  );

  tt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tick_i       (tick_en_i),
    .hit_i        (hit),
    .mode_i       (mode),
    .cnt_we_i     (cnt_we),
    .cnt_wdata_i  (wr_data_i),
    .mode_we_i    (mode_we),
    .mode_wdata_i (tt_mode_e'(wr_data_i[CNT_W-1:CNT_W-2])),
    .cnt_o        (cnt),
    .run_o        (run)
  );

  tt_mode_reg #(.CNT_W(CNT_W)) u_mode (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (mode_we),
    .wdata_i  (wr_data_i),
    .hit_i    (hit),
    .mode_o   (mode),
    .ie_o     (ie),
    .pend_o   (pend),
    .period_o (period)
  );

  assign count_o = cnt;
  assign mode_o  = {mode, ie, pend, period};
  assign irq_o   = pend && ie;

  // R8
  irq_masked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_o[CNT_W-3] |-> !irq_o);
  // R1
  reset_state_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (count_o == '0 && mode_o == '0 && !irq_o));
endmodule

// File: tb/sim_tick_timer.sv
module sim_tick_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0, wr_en = 1'b0, wr_sel = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] count, mreg;
  logic        irq;

  always #4 clk = ~clk;

  tick_timer u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_en_i(tick_en), .wr_en_i(wr_en),
    .wr_sel_i(wr_sel), .wr_data_i(wr_data), .count_o(count), .mode_o(mreg), .irq_o(irq)
  );

  typedef struct { string req; logic [31:0] cnt; logic [31:0] mr; logic irq; } exp_t;
  exp_t q[$];
  int checks = 0, errors = 0;
  string cur = "R1";

  // reference state from the requirements
  logic [31:0] m_cnt = '0;
  logic [1:0]  m_mode = 2'b00;
  logic        m_ie = 0, m_pend = 0, m_run = 0;
  logic [27:0] m_per = '0;

  function automatic logic [31:0] m_reg();
    return {m_mode, m_ie, m_pend, m_per};
  endfunction

  task automatic push();
    exp_t e;
    e.req = cur; e.cnt = m_cnt; e.mr = m_reg(); e.irq = m_pend & m_ie;
    q.push_back(e);
  endtask

  task automatic cyc(input logic t, input logic we, input logic sel, input logic [31:0] d);
    logic hit, n_pend, n_run;
    logic [31:0] n_cnt;
    tick_en = t; wr_en = we; wr_sel = sel; wr_data = d;
    hit    = m_run && t && (m_cnt[27:0] == m_per);
    n_pend = (we && sel) ? ((hit && m_ie) || (m_pend && d[28])) : (m_pend || (hit && m_ie));
    n_cnt  = m_cnt;
    if (we && !sel) n_cnt = d;
    else if (m_run && t) begin
      if (hit && m_mode == 2'b01)      n_cnt = '0;
      else if (hit && m_mode == 2'b10) n_cnt = m_cnt;
      else                             n_cnt = m_cnt + 1;
    end
    n_run = m_run;
    if (we && sel) n_run = (d[31:30] != 2'b00);
    else if (hit && m_mode == 2'b10) n_run = 1'b0;
    if (we && sel) begin m_mode = d[31:30]; m_ie = d[29]; m_per = d[27:0]; end
    m_pend = n_pend; m_cnt = n_cnt; m_run = n_run;
    @(posedge clk); #1;
    tick_en = 0; wr_en = 0; wr_sel = 0; wr_data = '0;
    push();
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cyc(1, 0, 0, 0);
  endtask
  task automatic wr_cnt(input logic [31:0] v);  cyc(0, 1, 0, v); endtask
  task automatic wr_mode(input logic [1:0] m, input logic ie, input logic ip, input logic [27:0] p);
    cyc(0, 1, 1, {m, ie, ip, p});
  endtask

  // monitor
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (count !== e.cnt || mreg !== e.mr || irq !== e.irq) begin
        errors++;
        $display("FAIL %s: cnt=%h mode=%h irq=%b expected cnt=%h mode=%h irq=%b",
                 e.req, count, mreg, irq, e.cnt, e.mr, e.irq);
      end
    end
  end

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 100000) begin
      errors++;
      $display("FAIL watchdog: cycles=%0d expected < 100000", wd);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    cur = "R1"; push();
    @(posedge clk); #1;
    cur = "R2"; ticks(3);                       // stopped: holds 0
    cur = "R3"; wr_cnt(32'd100); wr_cnt(32'h1234_5678);
    cur = "R3"; cyc(1, 1, 0, 32'd7);            // write beats tick
    // continuous, ie, period 5
    cur = "R11"; wr_cnt(0); wr_mode(2'b11, 1, 0, 28'd5);
    cur = "R6"; ticks(4);
    cur = "R4"; ticks(3);
    cur = "R2"; cyc(0, 0, 0, 0); cyc(0, 0, 0, 0); ticks(2);
    cur = "R7"; wr_mode(2'b11, 1, 1, 28'd5);    // writing 1 keeps
    cur = "R8"; wr_mode(2'b11, 0, 1, 28'd5);    // masked, still pending
    cur = "R7"; wr_mode(2'b11, 1, 0, 28'd5);    // clear
    ticks(2);
    // clear in same cycle as match: match wins
    cur = "R7"; wr_cnt(32'd4); wr_mode(2'b11, 1, 0, 28'd4);
    cyc(1, 1, 1, {2'b11, 1'b1, 1'b0, 28'd4});
    wr_mode(2'b11, 1, 0, 28'd4);
    // ie off: no pending on match
    cur = "R4"; wr_cnt(32'd2); wr_mode(2'b11, 0, 0, 28'd3); ticks(4);
    // restart, period 3
    cur = "R5"; wr_cnt(0); wr_mode(2'b01, 1, 0, 28'd3); ticks(10);
    // one-shot, period 4
    cur = "R9"; wr_mode(2'b00, 0, 0, 28'd0); wr_cnt(0); wr_mode(2'b10, 1, 0, 28'd4);
    ticks(8);
    cur = "R9"; wr_mode(2'b10, 1, 0, 28'd6); ticks(5);
    // upper bits ignored in compare
    cur = "R10"; wr_mode(2'b01, 1, 0, 28'd2); wr_cnt(32'hF000_0001); ticks(3);
    // wrap
    cur = "R2"; wr_mode(2'b11, 0, 0, 28'd9); wr_cnt(32'hFFFF_FFFE); ticks(3);
    // disabled stops
    cur = "R11"; wr_mode(2'b00, 1, 0, 28'd9); ticks(4);
    cyc(0, 0, 0, 0); cyc(0, 0, 0, 0);
    @(negedge clk); @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule